// File: doc/BRIEF.md
# Interrupt Cause Register Unit

This block gathers single-cycle event pulses from up to 32 hardware sources into a cause register and turns them into one interrupt line. Software can hide any source behind a mask. The mask changes only through two write-only ports. One port sets mask bits and the other clears them, so two agents can each change their own bits without a read-modify-write race. A per-bit clear-mode register sets how each cause bit is acknowledged. With mode bit 1, reading the bit clears it. With mode bit 0, the host clears the bit by writing a 1 to it. A driver that writes back the word it just read therefore acknowledges exactly the bits that were set.

The register port is a plain strobe interface with no back-pressure. A read or write completes in the cycle its strobe is high, and read data is returned combinationally in that same cycle. Register side effects (clears, mask and mode updates) take effect at the following clock edge. Only one access is made per cycle. Addresses: 0 cause, 1 mask-set, 2 mask-clear, 3 clear-mode, 4 mask-value, 5 cause-monitor. All other addresses read as zero and ignore writes.

Top module: `irq_cause_unit`

## Requirements
- R1: After reset the cause register reads 0, the mask-value register reads all ones, the clear-mode register reads 0, and irq_o is 0.
- R2: An event pulse on bit i sets cause bit i at the next edge. An event in the same cycle as a clear of that bit leaves the bit set.
- R3: Writing word V to address 1 sets mask bits where V is 1 and leaves the other mask bits unchanged.
- R4: Writing word V to address 2 clears mask bits where V is 1 and leaves the other mask bits unchanged.
- R5: Address 3 holds the clear mode. It is read/write, and bit i = 1 selects clear-on-read for cause bit i.
- R6: Reading address 0 returns the cause word. At the next edge it clears the bits whose mode is 1 and keeps the bits whose mode is 0.
- R7: Writing V to address 0 or 5 clears cause bits where V is 1 and the mode is 0. Cause bits whose mode is 1 ignore the write.
- R8: Reading address 4 returns the mask and changes no cause, mask or mode state.
- R9: Reading address 5 returns cause AND NOT mask. It clears only those returned bits whose mode is 1, and masked cause bits are untouched.
- R10: irq_o equals, one cycle later, the OR over all bits of cause AND NOT mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 32 | Event pulses, one per cause bit |
| host_wr_i | input | 1 | Register write strobe |
| host_rd_i | input | 1 | Register read strobe |
| host_addr_i | input | 3 | Register address |
| host_wdata_i | input | 32 | Write data |
| host_rdata_o | output | 32 | Read data, valid in the strobe cycle |
| irq_o | output | 1 | Registered masked interrupt |

## Verification
The bench sets up a mix of clear modes so that one read clears some bits and keeps others. A design that applies one mode to the whole word would then return the wrong value on the second read. It fires an event in the same cycle as a clearing read; a design that lets the clear win loses that event. It reads the monitor with some cause bits masked and checks that those bits survive. It also checks that a masked source keeps irq_o low while an unmasked one raises it exactly one cycle after the cause sets. Both a missing register stage and an extra one would show up there.

// File: rtl/irq_cause_pkg.sv
package irq_cause_pkg;
  localparam int ADDR_W = 3;
  typedef enum logic [ADDR_W-1:0] {
    SEL_CAUSE = 3'd0,
    SEL_MSET  = 3'd1,
    SEL_MCLR  = 3'd2,
    SEL_MODE  = 3'd3,
    SEL_MVAL  = 3'd4,
    SEL_MON   = 3'd5
  } reg_sel_e;

  typedef struct packed {
    logic rd_cause;
    logic rd_mon;
    logic wr_cause;
    logic wr_mset;
    logic wr_mclr;
    logic wr_mode;
  } strobes_t;
endpackage

// File: rtl/icu_decode.sv
module icu_decode
  import irq_cause_pkg::*;
(
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  output strobes_t          stb
);
  always_comb begin
    stb          = '0;
    stb.rd_cause = rd_en && (addr == SEL_CAUSE);
    stb.rd_mon   = rd_en && (addr == SEL_MON);
    stb.wr_cause = wr_en && ((addr == SEL_CAUSE) || (addr == SEL_MON));
    stb.wr_mset  = wr_en && (addr == SEL_MSET);
    stb.wr_mclr  = wr_en && (addr == SEL_MCLR);
    stb.wr_mode  = wr_en && (addr == SEL_MODE);
  end
endmodule

// File: rtl/icu_ctrl_regs.sv
module icu_ctrl_regs #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mset,
  input  logic         mclr,
  input  logic         mode_wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] mask,
  output logic [W-1:0] mode
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask <= '1;
      mode <= '0;
    end else begin
      if (mset)    mask <= mask | wdata;
      if (mclr)    mask <= mask & ~wdata;
      if (mode_wr) mode <= wdata;
    end
  end
endmodule

// File: rtl/icu_cause_bank.sv
module icu_cause_bank #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic         rd_all,
  input  logic         rd_mon,
  input  logic         wr_clr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] mode,
  input  logic [W-1:0] mask,
  output logic [W-1:0] cause
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic clr_rd;
    logic clr_wr;
    assign clr_rd = mode[i] && (rd_all || (rd_mon && !mask[i]));
    assign clr_wr = !mode[i] && wr_clr && wdata[i];
    always_ff @(posedge clk) begin
      if (!rst_n) cause[i] <= 1'b0;
      else        cause[i] <= (cause[i] && !(clr_rd || clr_wr)) || evt[i];
    end
  end
endmodule

// File: rtl/icu_irq_out.sv
module icu_irq_out #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cause,
  input  logic [W-1:0] mask,
  output logic         irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |(cause & ~mask);
  end
endmodule

// File: rtl/irq_cause_unit.sv
module irq_cause_unit
  import irq_cause_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [W-1:0]      evt_i,
  input  logic              host_wr_i,
  input  logic              host_rd_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [W-1:0]      host_wdata_i,
  output logic [W-1:0]      host_rdata_o,
  output logic              irq_o
);
  strobes_t     stb;
  logic [W-1:0] cause_q;
  logic [W-1:0] mask_q;
  logic [W-1:0] mode_q;

  icu_decode u_dec (
    .wr_en (host_wr_i),
    .rd_en (host_rd_i),
    .addr  (host_addr_i),
    .stb   (stb)
  );

  icu_ctrl_regs #(.W(W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .mset    (stb.wr_mset),
    .mclr    (stb.wr_mclr),
    .mode_wr (stb.wr_mode),
    .wdata   (host_wdata_i),
    .mask    (mask_q),
    .mode    (mode_q)
  );

  icu_cause_bank #(.W(W)) u_cause (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt    (evt_i),
    .rd_all (stb.rd_cause),
    .rd_mon (stb.rd_mon),
    .wr_clr (stb.wr_cause),
    .wdata  (host_wdata_i),
    .mode   (mode_q),
    .mask   (mask_q),
    .cause  (cause_q)
  );

  icu_irq_out #(.W(W)) u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .cause (cause_q),
    .mask  (mask_q),
    .irq   (irq_o)
  );

  always_comb begin
    unique case (host_addr_i)
      SEL_CAUSE: host_rdata_o = cause_q;
      SEL_MODE:  host_rdata_o = mode_q;
      SEL_MVAL:  host_rdata_o = mask_q;
      SEL_MON:   host_rdata_o = cause_q & ~mask_q;
      default:   host_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/icu_checker.sv
module icu_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] evt,
  input logic         wr_en,
  input logic         rd_en,
  input logic [2:0]   addr,
  input logic [W-1:0] wdata,
  input logic [W-1:0] cause,
  input logic [W-1:0] mask,
  input logic [W-1:0] mode,
  input logic         irq
);
  assert_evt_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((cause & $past(evt)) == $past(evt)));

  assert_mask_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd1) |=>
      (mask == ($past(mask) | $past(wdata))));

  assert_mask_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd2) |=>
      (((mask & $past(wdata)) == '0) &&
       ((mask & ~$past(wdata)) == ($past(mask) & ~$past(wdata)))));

  assert_cor_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && addr == 3'd0) |=>
      ((cause & $past(mode) & ~$past(evt)) == '0));

  assert_mval_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && addr == 3'd4 && evt == '0) |=>
      ($stable(cause) && $stable(mask) && $stable(mode)));

  assert_irq_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == ($past(cause & ~mask) != '0)));
endmodule

bind irq_cause_unit icu_checker #(.W(W)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .evt   (evt_i),
  .wr_en (host_wr_i),
  .rd_en (host_rd_i),
  .addr  (host_addr_i),
  .wdata (host_wdata_i),
  .cause (cause_q),
  .mask  (mask_q),
  .mode  (mode_q),
  .irq   (irq_o)
);

// File: tb/irq_cause_unit_tb.sv
module irq_cause_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] evt = '0;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          n_run = 0;
  int          n_fail = 0;
  logic        done = 1'b0;

  always #4 clk = ~clk;

  irq_cause_unit u_dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .host_wr_i(wr), .host_rd_i(rd),
    .host_addr_i(addr), .host_wdata_i(wdata), .host_rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1 wr = 1'b0; wdata = '0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); rd = 1'b1; addr = a;
    #1 d = rdata;
    @(posedge clk); #1 rd = 1'b0;
  endtask

  task automatic fire(input logic [31:0] v);
    @(negedge clk); evt = v;
    @(posedge clk); #1 evt = '0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 irq", {31'd0, irq}, 32'd0);
    reg_rd(3'd0, d); check("R1 cause", d, 32'd0);
    reg_rd(3'd4, d); check("R1 mask", d, 32'hFFFF_FFFF);
    reg_rd(3'd3, d); check("R1 mode", d, 32'd0);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    reg_wr(3'd2, 32'h0000_000F);
    reg_rd(3'd4, d); check("R4 mask clear", d, 32'hFFFF_FFF0);
    reg_wr(3'd1, 32'h0000_0003);
    reg_rd(3'd4, d); check("R3 mask set", d, 32'hFFFF_FFF3);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    fire(32'h0000_0005);
    reg_rd(3'd0, d); check("R2 latch", d, 32'h5);
    reg_rd(3'd0, d); check("R7 no clear on read in w1c", d, 32'h5);
    reg_wr(3'd0, 32'h4);
    reg_rd(3'd0, d); check("R7 partial w1c", d, 32'h1);
    reg_wr(3'd0, 32'h1);
    reg_rd(3'd0, d); check("R7 write back", d, 32'h0);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    fire(32'h1);
    @(posedge clk); #1 check("R10 masked source", {31'd0, irq}, 32'd0);
    fire(32'h4);
    check("R10 not early", {31'd0, irq}, 32'd0);
    @(posedge clk); #1 check("R10 raise", {31'd0, irq}, 32'd1);
    reg_rd(3'd5, d); check("R9 monitor", d, 32'h4);
    reg_wr(3'd0, 32'h5);
    @(posedge clk); #1 check("R10 drop", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_cor();
    logic [31:0] d;
    reg_wr(3'd3, 32'h0000_000F);
    reg_rd(3'd3, d); check("R5 mode readback", d, 32'hF);
    fire(32'h11);
    reg_rd(3'd0, d); check("R6 first read", d, 32'h11);
    reg_rd(3'd0, d); check("R6 mixed mode", d, 32'h10);
    reg_wr(3'd0, 32'h10);
    fire(32'h2);
    reg_wr(3'd0, 32'h2);
    reg_rd(3'd0, d); check("R7 cor bit ignores write", d, 32'h2);
    reg_rd(3'd0, d); check("R6 cleared", d, 32'h0);
  endtask

  task automatic t_coincide();
    logic [31:0] d;
    fire(32'h1);
    @(negedge clk); rd = 1'b1; addr = 3'd0; evt = 32'h1;
    @(posedge clk); #1 rd = 1'b0; evt = '0;
    reg_rd(3'd0, d); check("R2 event beats clear", d, 32'h1);
    reg_rd(3'd0, d); check("R2 then cleared", d, 32'h0);
  endtask

  task automatic t_mon();
    logic [31:0] d;
    fire(32'h0000_000D);
    reg_rd(3'd5, d); check("R9 monitor value", d, 32'hC);
    reg_rd(3'd0, d); check("R9 masked bit kept", d, 32'h1);
  endtask

  task automatic t_mval();
    logic [31:0] d;
    fire(32'h100);
    reg_rd(3'd4, d); check("R8 mask value", d, 32'hFFFF_FFF3);
    reg_rd(3'd4, d);
    reg_rd(3'd3, d); check("R8 mode unchanged", d, 32'hF);
    reg_rd(3'd0, d); check("R8 cause unchanged", d, 32'h100);
    check("R10 bit8 masked", {31'd0, irq}, 32'd0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset(); t_mask(); t_w1c(); t_irq(); t_cor(); t_coincide(); t_mon(); t_mval();
        done = 1'b1;
      end
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          n_run++; n_fail++;
          $display("FAIL watchdog expired");
        end
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule